// File: doc/BRIEF.md
# Two-Stage Full-Width Vector Shifter

This block moves an entire 128-bit value toward its most significant end (left) or its least significant end (right). The distance can be any number of bit positions from 0 to 127. Bits pushed past either end are lost, and the positions that open up are loaded with zeros.

The shift is built from two stages. The first is a byte crossbar that moves the value by whole bytes. The second is a 0 to 7 bit shifter that finishes the job. Both counts come from the low seven bits of a 128-bit control vector. The byte count is the upper four of those bits and the bit count is the lower three, so the total distance is simply that 7-bit number.

A caller presents data, control and direction together with a valid strobe. The result appears from a single output register one clock later.

Top module: `vshift128`

## Requirements
- R1: With `in_left` = 0, the captured result is `in_data` shifted right (logical) by the shift amount, with zeros entering at bit 127.
- R2: With `in_left` = 1, the captured result is `in_data` shifted left by the shift amount, with zeros entering at bit 0.
- R3: The shift amount is `in_ctl[6:0]` read as an unsigned number. `in_ctl[6:3]` is the whole-byte count and `in_ctl[2:0]` is the residual bit count. If the vector's bits are numbered with 0 at the most significant end, these are positions 121 to 127.
- R4: `in_ctl[127:7]` have no effect on the result.
- R5: A shift amount of 0 returns `in_data` unchanged in either direction.
- R6: `out_valid` equals the value `in_valid` had one clock earlier.
- R7: While `in_valid` is 0, `out_data` keeps its previous value.
- R8: A synchronous, active-high `rst` clears `out_valid` and `out_data` to 0.
- R9: A byte count of 1 together with a bit count of 3 (`in_ctl[6:0]` = 7'b0001011) shifts by 11 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid this cycle |
| in_data | input | 128 | Value to shift |
| in_ctl | input | 128 | Control vector; bits [6:0] give the shift amount |
| in_left | input | 1 | 1 = shift left, 0 = shift right |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Shifted result |

## Verification
Every result is due exactly one rising edge after its operands are presented with `in_valid` high. The bench therefore drives each operation on a falling edge and compares `out_data` and `out_valid` at the next falling edge, which falls half a period after the capturing edge. The hold and valid-drop checks use the same timing: they sample one falling edge after a cycle with `in_valid` low. The stimulus is seeded random operands mixed with directed amounts: 0, 11, 8, 7 and 127 in both directions. It also includes random upper control bits, which must not change the result.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
    parameter int DATA_W = 128;
    parameter int BYTE_W = 8;
    localparam int NBYTES     = DATA_W / BYTE_W;
    localparam int BYTE_CNT_W = $clog2(NBYTES);
    localparam int BIT_CNT_W  = $clog2(BYTE_W);
    localparam int AMT_W      = BYTE_CNT_W + BIT_CNT_W;

    typedef enum logic { DIR_RIGHT = 1'b0, DIR_LEFT = 1'b1 } dir_e;

    typedef struct packed {
        logic [BYTE_CNT_W-1:0] nbytes;
        logic [BIT_CNT_W-1:0]  nbits;
    } shamt_t;

    function automatic shamt_t split_amount(input logic [AMT_W-1:0] raw);
        return shamt_t'(raw);
    endfunction
endpackage

// File: rtl/vshift_byte_stage.sv
module vshift_byte_stage
    import vshift_pkg::*;
(
    input  logic [DATA_W-1:0]     din,
    input  logic [BYTE_CNT_W-1:0] nbytes,
    input  dir_e                  dir,
    output logic [DATA_W-1:0]     dout
);
    // Crossbar: each output byte selects one source byte or zero.
    for (genvar o = 0; o < NBYTES; o++) begin : g_out
        logic [BYTE_W-1:0] sel;
        always_comb begin
            sel = '0;
            for (int s = 0; s < NBYTES; s++) begin
                if (dir == DIR_LEFT) begin
                    if (s + int'(nbytes) == o) sel = din[s*BYTE_W +: BYTE_W];
                end else begin
                    if (o + int'(nbytes) == s) sel = din[s*BYTE_W +: BYTE_W];
                end
            end
        end
        assign dout[o*BYTE_W +: BYTE_W] = sel;
    end
endmodule

// File: rtl/vshift_bit_stage.sv
module vshift_bit_stage
    import vshift_pkg::*;
(
    input  logic [DATA_W-1:0]    din,
    input  logic [BIT_CNT_W-1:0] nbits,
    input  dir_e                 dir,
    output logic [DATA_W-1:0]    dout
);
    always_comb begin
        if (dir == DIR_LEFT) dout = din << nbits;
        else                 dout = din >> nbits;
    end
endmodule

// File: rtl/vshift128.sv
module vshift128
    import vshift_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DATA_W-1:0] in_ctl,
    input  logic              in_left,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    shamt_t            amt;
    dir_e              dir;
    logic [DATA_W-1:0] coarse, fine;

    assign amt = split_amount(in_ctl[AMT_W-1:0]);   // R3 field decode
    assign dir = dir_e'(in_left);

    vshift_byte_stage u_bytes (
        .din(in_data), .nbytes(amt.nbytes), .dir(dir), .dout(coarse));
    vshift_bit_stage u_bits (
        .din(coarse), .nbits(amt.nbits), .dir(dir), .dout(fine));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= fine;
        end
    end

    // R6: valid follows by one clock
    p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drop_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R7: result held while idle
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    // R5: zero amount passes through
    p_zero_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ctl[AMT_W-1:0] == '0) |=> out_data == $past(in_data));
    // R1: right shift by at least one clears the top bit
    p_right_fill_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_left && in_ctl[AMT_W-1:0] != '0) |=> !out_data[DATA_W-1]);
    // R2: left shift by at least one clears the bottom bit
    p_left_fill_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_left && in_ctl[AMT_W-1:0] != '0) |=> !out_data[0]);
    // R4: control must be defined whenever an operation is presented
    p_ctl_known_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> !$isunknown(in_ctl));
endmodule

// File: tb/vshift128_tb.sv
module vshift128_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [DW-1:0] in_ctl = '0;
    logic          in_left = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vshift128 dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ctl(in_ctl), .in_left(in_left),
        .out_valid(out_valid), .out_data(out_data));

    function automatic logic [DW-1:0] exp_shift(input logic [DW-1:0] d,
                                                input logic [6:0] a, input logic l);
        return l ? (d << a) : (d >> a);
    endfunction

    function automatic logic [DW-1:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one operation at a falling edge; check at the next falling edge.
    task automatic run_op(input string req, input logic [DW-1:0] d,
                          input logic [DW-1:0] c, input logic l);
        in_valid = 1'b1; in_data = d; in_ctl = c; in_left = l;
        @(negedge clk);
        check({req, " valid"}, {127'd0, out_valid}, 128'd1);
        check(req, out_data, exp_shift(d, c[6:0], l));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] held;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 out_valid", {127'd0, out_valid}, 128'd0);
        check("R8 out_data", out_data, '0);
        rst = 1'b0;
        @(negedge clk);

        run_op("R5 zero right", rnd128(), 128'd0, 1'b0);
        run_op("R5 zero left", rnd128(), 128'd0, 1'b1);
        run_op("R9 eleven right", rnd128(), 128'h0B, 1'b0);
        run_op("R9 eleven left", rnd128(), 128'h0B, 1'b1);
        run_op("R3 byte only", rnd128(), 128'h08, 1'b0);
        run_op("R3 bit only", rnd128(), 128'h07, 1'b1);
        run_op("R1 max right", {DW{1'b1}}, 128'h7F, 1'b0);
        run_op("R2 max left", {DW{1'b1}}, 128'h7F, 1'b1);
        run_op("R4 upper ctl ignored", rnd128(), {{121{1'b1}}, 7'h15}, 1'b0);

        // R7 / R6: idle cycle holds data and drops valid
        held = out_data;
        in_valid = 1'b0; in_data = rnd128(); in_ctl = rnd128();
        @(negedge clk);
        check("R6 valid drop", {127'd0, out_valid}, 128'd0);
        check("R7 hold", out_data, held);

        for (int i = 0; i < 300; i++) begin
            logic [DW-1:0] c;
            logic l;
            c = rnd128();
            l = 1'(i % 2);
            run_op(l ? "R2 random left" : "R1 random right", rnd128(), c, l);
            if (i % 37 == 0) begin
                held = out_data;
                in_valid = 1'b0;
                in_data = rnd128();
                @(negedge clk);
                check("R7 random hold", out_data, held);
            end
        end
        in_valid = 1'b0;
        finish_run();
    end
endmodule